// File: doc/BRIEF.md
# Dual-Channel Serial Register and Interrupt Controller

This block is the register front end of a two-channel asynchronous serial controller. A byte-wide bus reaches a control port and a data port for each channel. Control accesses go through a per-channel pointer: a write at pointer zero loads the pointer and may carry a command, and the next control access reaches the selected register. After that access the pointer is zero again. The data port returns the received byte and accepts transmit bytes.

Each channel keeps receive and transmit interrupt pending flags and in-service flags. Receive service takes priority over transmit service. The block builds a shared interrupt vector and a shared pending register from these flags, and drives one interrupt line. Each channel also reports how many input clocks make one bit period, computed from its divisor and clock-mode settings. Received bytes arrive through a valid/ready handshake. Channel resets and a full reset are issued through the shared master-control register.

Write registers that have no effect in this block are accepted and dropped.

Top module: `dual_serial_ctl`

## Requirements
- R1: Address bit ADDR_SHIFT selects the control port (0) or the data port (1). Address bit ADDR_SHIFT+1 selects channel A (0) or channel B (1). An access to one channel leaves the other channel's registers unchanged.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. It adds 8 when bits 5:3 equal 1. The next control write or control read uses that register, and the pointer is 0 after that access.
- R3: After reset the following hold:
  - control register 0 reads 0x44, or 0x7C when DISABLED is set;
  - register 1 reads 0x07;
  - register 2 reads 0x06;
  - irq is low and rx_ready is low;
  - the bit period output is 4.
- R4: rx_ready is high only when write register 3 bit 0 is set and no byte is waiting. An accepted byte sets status bit 0 and is returned by a data read. The data read clears status bit 0.
- R5: An accepted byte makes the receive interrupt pending and raises irq when write register 1 bits 4:3 equal 01 or 10, but not when they equal 00 or 11. A data read removes the receive interrupt.
- R6: A data write makes the transmit interrupt pending, and irq rises when write register 1 bit 1 is set. A control command 5 (bits 5:3) clears the transmit interrupt.
- R7: The transmit interrupt enters service only while receive is not in service. Ending receive service promotes a pending transmit interrupt. Receive service ends by a data read or by command 7. Command 7 ends receive service if it is active, and otherwise ends transmit service.
- R8: Read register 2 returns a vector for the highest in-service source, in the order receive A, transmit A, receive B, transmit B.
  - With master bit 4 clear, the codes are 0x0C, 0x08, 0x04, 0x00, and 0x06 for none.
  - With master bit 4 set, the codes are 0x30, 0x10, 0x20, 0x00, and 0x60 for none.
- R9: Read register 3 on channel A returns the enabled pending interrupts: bit 5 receive A, bit 4 transmit A, bit 2 receive B, bit 1 transmit B. On channel B it reads 0.
- R10: A pulse on brk_in sets status bit 7 of that channel. irq rises while write register 15 bit 7 is set, and that bit is 1 after reset.
- R11: A write to register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both and clears master bit 4.
- R12: The bit period output equals 2 * (divisor + 2) * k. The divisor is {register 13, register 12}, and k is 1, 16, 32 or 64 for register 4 bits 7:6 = 00, 01, 10, 11. Registers 12 and 13 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_SHIFT+2 | Port select and channel select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| rx_valid | input | 2 | Received byte offered, bit 0 channel A |
| rx_data | input | 16 | Received bytes, bits 7:0 channel A |
| rx_ready | output | 2 | Channel can take a byte |
| brk_in | input | 2 | Break detected pulse per channel |
| irq | output | 1 | Combined interrupt request |
| bit_div_a | output | 24 | Input clocks per bit, channel A |
| bit_div_b | output | 24 | Input clocks per bit, channel B |

## Verification
The bench targets the case where a transmit interrupt arrives while receive is in service. A design that lets transmit into service too early shows the transmit vector while a byte still waits. A design that never promotes transmit leaves the vector at the no-interrupt code after command 7 or a data read.

The bench checks command 7 with only transmit in service, which must leave irq high with vector 0x06. It checks that partial resets leave the other channel's divisor intact, and that the status-high codes are used, including in the mixed case where transmit A outranks receive B. It also checks random divisors and clock modes against its own period formula, and random received bytes through channel B.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;
  localparam int REG_CNT = 16;
  localparam int PTR_W   = $clog2(REG_CNT);
  localparam int DIV_W   = 16;
  localparam int BDIV_W  = DIV_W + 8;

  typedef enum logic [2:0] {SRC_NONE, SRC_RXA, SRC_TXA, SRC_RXB, SRC_TXB} irq_src_e;

  typedef struct packed {
    logic rx_avail;
    logic rx_pend;
    logic rx_ius;
    logic tx_pend;
    logic tx_ius;
    logic brk;
  } chan_flags_t;

  typedef struct packed {
    logic             tx_ie;
    logic [1:0]       rx_mode;
    logic             rx_en;
    logic [1:0]       clk_mode;
    logic [DIV_W-1:0] div;
    logic             brk_ie;
  } chan_cfg_t;

  localparam chan_cfg_t   CFG_RST = '{tx_ie: 1'b0, rx_mode: 2'b00, rx_en: 1'b0,
                                      clk_mode: 2'b00, div: '0, brk_ie: 1'b1};
  localparam chan_flags_t FLG_RST = '0;

  function automatic logic [7:0] vec_code(irq_src_e s, logic hi);
    logic [7:0] lo_c, hi_c;
    case (s)
      SRC_RXA: begin lo_c = 8'h0C; hi_c = 8'h30; end
      SRC_TXA: begin lo_c = 8'h08; hi_c = 8'h10; end
      SRC_RXB: begin lo_c = 8'h04; hi_c = 8'h20; end
      SRC_TXB: begin lo_c = 8'h00; hi_c = 8'h00; end
      default: begin lo_c = 8'h06; hi_c = 8'h60; end
    endcase
    return hi ? hi_c : lo_c;
  endfunction

  // clocks per bit: (div+2) doubled, then scaled by 1/16/32/64
  function automatic logic [BDIV_W-1:0] clocks_per_bit(logic [DIV_W-1:0] d, logic [1:0] m);
    logic [BDIV_W-1:0] base;
    base = BDIV_W'(d) + BDIV_W'(2);
    case (m)
      2'b00:   return base << 1;
      2'b01:   return base << 5;
      2'b10:   return base << 6;
      default: return base << 7;
    endcase
  endfunction
endpackage

// File: rtl/sctl_chan.sv
`timescale 1ns/1ps
module sctl_chan
  import sctl_pkg::*;
#(
  parameter bit DISABLED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [7:0]        wdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              brk_in,
  output logic              rx_ready,
  output logic [PTR_W-1:0]  ptr,
  output logic              reg9_wr,
  output chan_flags_t       flags,
  output chan_cfg_t         cfg,
  output logic [7:0]        loc_rdata,
  output logic [7:0]        rx_byte,
  output logic [BDIV_W-1:0] bit_div
);
  logic [PTR_W-1:0] ptr_q, ptr_n;
  chan_flags_t      flg_q, flg_n;
  chan_cfg_t        cfg_q, cfg_n;
  logic [7:0]       rxb_q;
  logic [2:0]       cmd;
  logic             cmd_wr, reg_wr, accept, clr_tx, end_ius, promo;

  assign cmd      = wdata[5:3];
  assign cmd_wr   = ctl_wr && (ptr_q == '0);
  assign reg_wr   = ctl_wr && (ptr_q != '0);
  assign clr_tx   = cmd_wr && (cmd == 3'd5);
  assign end_ius  = cmd_wr && (cmd == 3'd7);
  assign rx_ready = cfg_q.rx_en && !flg_q.rx_avail;
  assign accept   = rx_valid && rx_ready;
  assign reg9_wr  = reg_wr && (ptr_q == PTR_W'(9));

  always_comb begin
    ptr_n = ptr_q;
    if (cmd_wr)                ptr_n = {cmd == 3'd1, wdata[2:0]};
    else if (reg_wr || ctl_rd) ptr_n = '0;
  end

  always_comb begin
    cfg_n = cfg_q;
    if (reg_wr) begin
      case (ptr_q)
        PTR_W'(1):  begin cfg_n.tx_ie = wdata[1]; cfg_n.rx_mode = wdata[4:3]; end
        PTR_W'(3):  cfg_n.rx_en = wdata[0];
        PTR_W'(4):  cfg_n.clk_mode = wdata[7:6];
        PTR_W'(12): cfg_n.div[7:0] = wdata;
        PTR_W'(13): cfg_n.div[15:8] = wdata;
        PTR_W'(15): cfg_n.brk_ie = wdata[7];
        default: ;
      endcase
    end
  end

  // event order: read, accept, write/commands, then transmit promotion
  always_comb begin
    flg_n = flg_q;
    promo = 1'b0;
    if (dat_rd) begin
      flg_n.rx_avail = 1'b0;
      flg_n.rx_pend  = 1'b0;
      flg_n.rx_ius   = 1'b0;
      promo          = 1'b1;
    end
    if (accept) begin
      flg_n.rx_avail = 1'b1;
      flg_n.rx_pend  = 1'b1;
      flg_n.rx_ius   = 1'b1;
    end
    if (dat_wr) begin
      flg_n.tx_pend = 1'b1;
      promo         = 1'b1;
    end
    if (clr_tx) begin
      flg_n.tx_pend = 1'b0;
      flg_n.tx_ius  = 1'b0;
    end
    if (end_ius) begin
      if (flg_q.rx_ius) begin
        flg_n.rx_ius = 1'b0;
        promo        = 1'b1;
      end else begin
        flg_n.tx_ius = 1'b0;
      end
    end
    if (brk_in) flg_n.brk = 1'b1;
    if (promo && flg_n.tx_pend && !flg_n.rx_ius) flg_n.tx_ius = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      flg_q <= FLG_RST;
      cfg_q <= CFG_RST;
      rxb_q <= '0;
    end else if (chan_rst) begin
      ptr_q <= '0;
      flg_q <= FLG_RST;
      cfg_q <= CFG_RST;
      rxb_q <= '0;
    end else begin
      ptr_q <= ptr_n;
      flg_q <= flg_n;
      cfg_q <= cfg_n;
      if (accept) rxb_q <= rx_data;
    end
  end

  always_comb begin
    case (ptr_q)
      PTR_W'(0):  loc_rdata = {flg_q.brk, 1'b1, {3{DISABLED}}, 1'b1, 1'b0, flg_q.rx_avail};
      PTR_W'(1):  loc_rdata = 8'h07;
      PTR_W'(8):  loc_rdata = rxb_q;
      PTR_W'(12): loc_rdata = cfg_q.div[7:0];
      PTR_W'(13): loc_rdata = cfg_q.div[15:8];
      default:    loc_rdata = 8'h00;
    endcase
  end

  assign ptr     = ptr_q;
  assign flags   = flg_q;
  assign cfg     = cfg_q;
  assign rx_byte = rxb_q;
  assign bit_div = clocks_per_bit(cfg_q.div, cfg_q.clk_mode);
endmodule

// File: rtl/sctl_irq.sv
`timescale 1ns/1ps
module sctl_irq
  import sctl_pkg::*;
(
  input  chan_flags_t flg_a,
  input  chan_flags_t flg_b,
  input  chan_cfg_t   cfg_a,
  input  chan_cfg_t   cfg_b,
  input  logic        status_hi,
  output logic [7:0]  vector,
  output logic [7:0]  pend_reg,
  output logic        irq
);
  logic [1:0] rx_on, tx_on, brk_on;
  irq_src_e   src;

  assign rx_on[0]  = flg_a.rx_pend && (cfg_a.rx_mode == 2'b01 || cfg_a.rx_mode == 2'b10);
  assign rx_on[1]  = flg_b.rx_pend && (cfg_b.rx_mode == 2'b01 || cfg_b.rx_mode == 2'b10);
  assign tx_on[0]  = flg_a.tx_pend && cfg_a.tx_ie;
  assign tx_on[1]  = flg_b.tx_pend && cfg_b.tx_ie;
  assign brk_on[0] = flg_a.brk && cfg_a.brk_ie;
  assign brk_on[1] = flg_b.brk && cfg_b.brk_ie;

  assign irq      = |{rx_on, tx_on, brk_on};
  assign pend_reg = {2'b00, rx_on[0], tx_on[0], 1'b0, rx_on[1], tx_on[1], 1'b0};

  always_comb begin
    if (flg_a.rx_ius)      src = SRC_RXA;
    else if (flg_a.tx_ius) src = SRC_TXA;
    else if (flg_b.rx_ius) src = SRC_RXB;
    else if (flg_b.tx_ius) src = SRC_TXB;
    else                   src = SRC_NONE;
  end

  assign vector = vec_code(src, status_hi);
endmodule

// File: rtl/dual_serial_ctl.sv
`timescale 1ns/1ps
module dual_serial_ctl
  import sctl_pkg::*;
#(
  parameter int  ADDR_SHIFT = 0,
  parameter bit  DISABLED   = 1'b0,
  localparam int ADDR_W     = ADDR_SHIFT + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        rx_valid,
  input  logic [15:0]       rx_data,
  output logic [1:0]        rx_ready,
  input  logic [1:0]        brk_in,
  output logic              irq,
  output logic [BDIV_W-1:0] bit_div_a,
  output logic [BDIV_W-1:0] bit_div_b
);
  logic              sel_dat, sel_ch, status_hi, any9;
  logic [1:0]        ctl_wr_v, ctl_rd_v, dat_wr_v, dat_rd_v, reg9_v, chan_rst, ctl_acc;
  logic [1:0]        avail_w, rxp_w, rxi_w, txp_w, txi_w, brk_w;
  logic [1:0]        rst_code;
  logic [PTR_W-1:0]  ptr_v [2];
  chan_flags_t       flg [2];
  chan_cfg_t         cfg [2];
  logic [7:0]        loc_rd [2];
  logic [7:0]        rxb [2];
  logic [BDIV_W-1:0] bdiv [2];
  logic [7:0]        vector, pend_reg;
  logic [PTR_W-1:0]  ptr_a, cur_ptr;

  assign sel_dat = bus_addr[ADDR_SHIFT];
  assign sel_ch  = bus_addr[ADDR_SHIFT+1];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign ctl_wr_v[c] = bus_wr && !sel_dat && (sel_ch == 1'(c));
    assign ctl_rd_v[c] = bus_rd && !sel_dat && (sel_ch == 1'(c));
    assign dat_wr_v[c] = bus_wr &&  sel_dat && (sel_ch == 1'(c));
    assign dat_rd_v[c] = bus_rd &&  sel_dat && (sel_ch == 1'(c));
    assign ctl_acc[c]  = ctl_wr_v[c] || ctl_rd_v[c];

    sctl_chan #(.DISABLED(DISABLED)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_rst (chan_rst[c]),
      .ctl_wr   (ctl_wr_v[c]),
      .ctl_rd   (ctl_rd_v[c]),
      .dat_wr   (dat_wr_v[c]),
      .dat_rd   (dat_rd_v[c]),
      .wdata    (bus_wdata),
      .rx_valid (rx_valid[c]),
      .rx_data  (rx_data[8*c +: 8]),
      .brk_in   (brk_in[c]),
      .rx_ready (rx_ready[c]),
      .ptr      (ptr_v[c]),
      .reg9_wr  (reg9_v[c]),
      .flags    (flg[c]),
      .cfg      (cfg[c]),
      .loc_rdata(loc_rd[c]),
      .rx_byte  (rxb[c]),
      .bit_div  (bdiv[c])
    );

    assign avail_w[c] = flg[c].rx_avail;
    assign rxp_w[c]   = flg[c].rx_pend;
    assign rxi_w[c]   = flg[c].rx_ius;
    assign txp_w[c]   = flg[c].tx_pend;
    assign txi_w[c]   = flg[c].tx_ius;
    assign brk_w[c]   = flg[c].brk;
  end

  // master control: bits 7:6 reset request, bit 4 status-high vector codes
  assign any9     = |reg9_v;
  assign rst_code = any9 ? bus_wdata[7:6] : 2'b00;
  assign chan_rst = {rst_code[0], rst_code[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       status_hi <= 1'b0;
    else if (any9 && rst_code == 2'b11) status_hi <= 1'b0;
    else if (any9 && rst_code == 2'b00) status_hi <= bus_wdata[4];
  end

  sctl_irq u_irq (
    .flg_a    (flg[0]),
    .flg_b    (flg[1]),
    .cfg_a    (cfg[0]),
    .cfg_b    (cfg[1]),
    .status_hi(status_hi),
    .vector   (vector),
    .pend_reg (pend_reg),
    .irq      (irq)
  );

  assign ptr_a   = ptr_v[0];
  assign cur_ptr = sel_ch ? ptr_v[1] : ptr_v[0];

  always_comb begin
    if (sel_dat)                     bus_rdata = sel_ch ? rxb[1] : rxb[0];
    else if (cur_ptr == PTR_W'(2))   bus_rdata = vector;
    else if (cur_ptr == PTR_W'(3))   bus_rdata = sel_ch ? 8'h00 : pend_reg;
    else                             bus_rdata = sel_ch ? loc_rd[1] : loc_rd[0];
  end

  assign bit_div_a = bdiv[0];
  assign bit_div_b = bdiv[1];
endmodule

// File: rtl/sctl_checker.sv
`timescale 1ns/1ps
module sctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rx_valid,
  input logic [1:0] rx_ready,
  input logic [1:0] avail,
  input logic [1:0] rx_pend,
  input logic [1:0] rx_ius,
  input logic [1:0] tx_pend,
  input logic [1:0] tx_ius,
  input logic [1:0] brk,
  input logic [1:0] chan_rst,
  input logic [1:0] dat_rd,
  input logic [1:0] ctl_acc,
  input logic [3:0] ptr_a,
  input logic       irq
);
  AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc[0] && ptr_a != 4'd0) |=> (ptr_a == 4'd0)); // R2
  AST_ACCEPT_SETS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid[0] && rx_ready[0] && !chan_rst[0]) |=> avail[0]); // R4
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    avail[1] |-> !rx_ready[1]); // R4
  AST_TX_BEHIND_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ius[0]) |-> !rx_ius[0]); // R7
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|rx_pend || |tx_pend || |brk)); // R5
  AST_READ_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd[1] && !(rx_valid[1] && rx_ready[1]) && !chan_rst[1]) |=> !rx_pend[1]); // R5
endmodule

bind dual_serial_ctl sctl_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .avail   (avail_w),
  .rx_pend (rxp_w),
  .rx_ius  (rxi_w),
  .tx_pend (txp_w),
  .tx_ius  (txi_w),
  .brk     (brk_w),
  .chan_rst(chan_rst),
  .dat_rd  (dat_rd_v),
  .ctl_acc (ctl_acc),
  .ptr_a   (ptr_a),
  .irq     (irq)
);

// File: tb/dual_serial_ctl_tb.sv
`timescale 1ns/1ps
module dual_serial_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [1:0]  rx_valid = '0, rx_ready, brk_in = '0;
  logic [15:0] rx_data = '0;
  logic        irq;
  logic [23:0] bit_div_a, bit_div_b;
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  rv;

  always #2.5 clk = ~clk;

  dual_serial_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .brk_in(brk_in), .irq(irq), .bit_div_a(bit_div_a), .bit_div_b(bit_div_b)
  );

  function automatic logic [23:0] exp_div(logic [15:0] d, logic [1:0] m);
    int k;
    k = (m == 2'd0) ? 1 : (m == 2'd1) ? 16 : (m == 2'd2) ? 32 : 64;
    return 24'(2 * (int'(d) + 2) * k);
  endfunction

  // src: 0 none, 1 rx A, 2 tx A, 3 rx B, 4 tx B
  function automatic logic [7:0] exp_vec(int src, bit hi);
    logic [7:0] lo_t [5] = '{8'h06, 8'h0C, 8'h08, 8'h04, 8'h00};
    logic [7:0] hi_t [5] = '{8'h60, 8'h30, 8'h10, 8'h20, 8'h00};
    return hi ? hi_t[src] : lo_t[src];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_w(input int ch, input bit dat, input logic [7:0] v);
    @(negedge clk); bus_addr = {ch[0], dat}; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_r(input int ch, input bit dat, output logic [7:0] v);
    @(negedge clk); bus_addr = {ch[0], dat}; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_ptr(input int ch, input int n);
    if (n < 8) bus_w(ch, 1'b0, 8'(n));
    else       bus_w(ch, 1'b0, 8'h08 | 8'(n - 8));
  endtask

  task automatic wreg(input int ch, input int n, input logic [7:0] v);
    set_ptr(ch, n); bus_w(ch, 1'b0, v);
  endtask

  task automatic rreg(input int ch, input int n, output logic [7:0] v);
    set_ptr(ch, n); bus_r(ch, 1'b0, v);
  endtask

  task automatic push(input int ch, input logic [7:0] v);
    @(negedge clk); rx_valid[ch] = 1'b1; rx_data[8*ch +: 8] = v;
    @(negedge clk); rx_valid[ch] = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    bus_r(0, 1'b0, rv); check("R3 status A", rv, 8'h44);
    rreg(0, 1, rv);     check("R3 reg1 A", rv, 8'h07);
    rreg(1, 2, rv);     check("R3 vector", rv, 8'h06);
    check("R3 irq", irq, 1'b0);
    check("R3 rx_ready", rx_ready, 2'b00);
    check("R3 bit_div", bit_div_a, 24'd4);

    // R2 pointer and R1 channel select
    wreg(0, 12, 8'h34);
    wreg(1, 12, 8'h56);
    rreg(0, 12, rv); check("R2 read reg12 A", rv, 8'h34);
    bus_r(0, 1'b0, rv); check("R2 pointer back to 0", rv, 8'h44);
    rreg(1, 12, rv); check("R1 reg12 B", rv, 8'h56);
    check("R1 div A", bit_div_a, exp_div(16'h0034, 2'd0));

    // R4 receive path
    wreg(0, 3, 8'h01);
    check("R4 ready after enable", rx_ready[0], 1'b1);
    push(0, 8'hA5);
    check("R4 ready blocked", rx_ready[0], 1'b0);
    bus_r(0, 1'b0, rv); check("R4 avail set", rv[0], 1'b1);
    check("R5 irq mode 00", irq, 1'b0);
    bus_r(0, 1'b1, rv); check("R4 data", rv, 8'hA5);
    bus_r(0, 1'b0, rv); check("R4 avail cleared", rv[0], 1'b0);

    // R5 receive interrupt modes
    wreg(0, 1, 8'h10);
    push(0, 8'h3C);
    check("R5 irq mode 10", irq, 1'b1);
    rreg(0, 3, rv); check("R9 pending rx A", rv, 8'h20);
    rreg(1, 3, rv); check("R9 B reads 0", rv, 8'h00);
    rreg(0, 2, rv); check("R8 vec rx A", rv, exp_vec(1, 0));
    bus_r(0, 1'b1, rv); check("R5 irq cleared by read", irq, 1'b0);
    wreg(0, 1, 8'h18);
    push(0, 8'h3D);
    check("R5 irq mode 11", irq, 1'b0);
    bus_r(0, 1'b1, rv);

    // R6 transmit interrupt
    wreg(0, 1, 8'h02);
    bus_w(0, 1'b1, 8'h77);
    check("R6 irq tx", irq, 1'b1);
    rreg(0, 2, rv); check("R8 vec tx A", rv, exp_vec(2, 0));
    bus_w(0, 1'b0, 8'h28);
    check("R6 irq cleared cmd5", irq, 1'b0);
    rreg(0, 2, rv); check("R6 vec none", rv, exp_vec(0, 0));

    // R7 in-service ordering
    wreg(0, 1, 8'h12);
    push(0, 8'h11);
    bus_w(0, 1'b1, 8'h55);
    rreg(0, 2, rv); check("R7 rx keeps service", rv, exp_vec(1, 0));
    bus_w(0, 1'b0, 8'h38);
    rreg(0, 2, rv); check("R7 cmd7 promotes tx", rv, exp_vec(2, 0));
    check("R7 irq still high", irq, 1'b1);
    bus_r(0, 1'b1, rv);
    rreg(0, 2, rv); check("R7 vec after read", rv, exp_vec(2, 0));
    bus_w(0, 1'b0, 8'h38);
    rreg(0, 2, rv); check("R7 cmd7 ends tx service", rv, exp_vec(0, 0));
    check("R7 tx still pending", irq, 1'b1);
    bus_w(0, 1'b0, 8'h28);
    push(0, 8'h12);
    bus_w(0, 1'b1, 8'h56);
    bus_r(0, 1'b1, rv);
    rreg(0, 2, rv); check("R7 read promotes tx", rv, exp_vec(2, 0));
    bus_w(0, 1'b0, 8'h28);
    check("R7 all clear", irq, 1'b0);

    // R8 status-high codes
    wreg(0, 9, 8'h10);
    wreg(1, 3, 8'h01);
    wreg(1, 1, 8'h10);
    push(1, 8'h22);
    rreg(1, 2, rv); check("R8 hi rx B", rv, exp_vec(3, 1));
    bus_w(0, 1'b1, 8'h99);
    rreg(0, 2, rv); check("R8 hi tx A over rx B", rv, exp_vec(2, 1));
    bus_r(1, 1'b1, rv);
    bus_w(0, 1'b0, 8'h28);
    rreg(0, 2, rv); check("R8 hi none", rv, exp_vec(0, 1));
    wreg(0, 9, 8'h00);
    rreg(0, 2, rv); check("R8 lo none", rv, exp_vec(0, 0));

    // random receive bytes through channel B
    wreg(1, 1, 8'h08);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      push(1, b);
      check("R5 rand irq", irq, 1'b1);
      bus_r(1, 1'b1, rv); check("R4 rand data", rv, b);
      check("R5 rand clear", irq, 1'b0);
    end

    // R10 break
    @(negedge clk); brk_in[1] = 1'b1;
    @(negedge clk); brk_in[1] = 1'b0;
    bus_r(1, 1'b0, rv); check("R10 break status", rv, 8'hC4);
    check("R10 break irq", irq, 1'b1);

    // R11 resets
    wreg(0, 9, 8'h40);
    bus_r(1, 1'b0, rv); check("R11 B status", rv, 8'h44);
    check("R11 irq after B reset", irq, 1'b0);
    check("R11 B ready", rx_ready[1], 1'b0);
    rreg(0, 12, rv); check("R11 A kept", rv, 8'h34);
    wreg(1, 9, 8'h80);
    check("R11 A ready", rx_ready[0], 1'b0);
    check("R11 A div", bit_div_a, 24'd4);
    wreg(0, 9, 8'h10);
    wreg(0, 9, 8'hC0);
    rreg(0, 2, rv); check("R11 full reset clears hi", rv, exp_vec(0, 0));

    // R12 random divisors
    for (int i = 0; i < 16; i++) begin
      int          ch;
      logic [15:0] d;
      logic [1:0]  m;
      ch = int'($urandom % 2);
      d  = 16'($urandom);
      m  = 2'($urandom);
      if (i == 0) d = 16'hFFFF;
      if (i == 0) m = 2'd3;
      wreg(ch, 12, d[7:0]);
      wreg(ch, 13, d[15:8]);
      wreg(ch, 4, {m, 6'h04});
      check("R12 bit_div", (ch == 0) ? bit_div_a : bit_div_b, exp_div(d, m));
      rreg(ch, 13, rv); check("R12 reg13 readback", rv, d[15:8]);
    end

    finish_run();
  end
endmodule